// File: doc/BRIEF.md
# Banked Dual-Output Interrupt Controller

This block gathers 96 level-sensitive interrupt sources into three 32-bit banks and drives two request lines to a processor: an ordinary interrupt request and a fast interrupt request. A source that goes high latches a pending bit. The bit stays set until software clears it by writing a one to it. A per-bit mask register blocks a source from both request lines. A per-bit select register also routes an unmasked pending source to the fast line. The enable register is plain storage and has no effect on either line.

Software reaches the block over a simple synchronous word bus. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from the address. Four scalar registers (vector, base address, protect, NMI control) are also held here for software. The block does nothing with them beyond storing them.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every mapped register reads zero and both `irq_o` and `fiq_o` are low.
- R2: Source n sets bit (n mod 32) of the pending register of bank (n / 32). The pending registers sit at byte offsets 0x10, 0x14 and 0x18 for banks 0, 1 and 2.
- R3: A pending bit stays set after its source falls, until software clears it.
- R4: A write to a pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. If the source is still high at that edge, its bit stays set.
- R5: `irq_o` is high when any bank holds a bit that is pending and whose mask bit (offsets 0x50/0x54/0x58) is 0. `irq_o` is registered and follows the register state one clock later. A source sampled high at edge k therefore raises `irq_o` at edge k+1.
- R6: `fiq_o` is high when any bank holds a bit that is pending, unmasked, and set in the select register (offsets 0x30/0x34/0x38). It has the same timing as `irq_o`.
- R7: The enable registers (offsets 0x40/0x44/0x48) read back as written and never change `irq_o` or `fiq_o`.
- R8: The vector register (0x00) and base-address register (0x04) store a written value with bits [1:0] forced to zero. The protect register (0x08) and NMI register (0x0C) store all 32 bits.
- R9: The fast-pending registers (0x20/0x24/0x28) are never set by sources and read zero.
- R10: A read of an unmapped offset returns zero, and a write to one changes nothing. Unmapped offsets are: a nonzero byte offset in bits [1:0], any offset at or above 0x60, and bank index 3 within a banked group.
- R11: Within each banked group (bits [7:4] of the offset equal to 1 to 5), offset bits [3:2] pick the bank. A write to one bank leaves the other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 96 | Level interrupt sources, bit n is source n |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 10 | Byte offset within the 0x400 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A wrong pending, mask or select bit shows up at the ports in two ways. It is visible on `bus_rdata` in the same cycle its register is addressed. It is visible on `irq_o` or `fiq_o` one clock after it is stored. The bench walks every one of the 96 sources through capture, readback, output assertion and clearing. A bank or bit-position error therefore appears within three cycles of the faulty source being raised. Decode faults appear as a nonzero read or a disturbed neighbour register right after the stray write.

// File: rtl/banked_pic_pkg.sv
package banked_pic_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 10;

  // offset bits [7:4]: register group
  localparam logic [3:0] GRP_SCALAR = 4'd0;
  localparam logic [3:0] GRP_PEND   = 4'd1;
  localparam logic [3:0] GRP_FPEND  = 4'd2;
  localparam logic [3:0] GRP_SEL    = 4'd3;
  localparam logic [3:0] GRP_ENA    = 4'd4;
  localparam logic [3:0] GRP_MASK   = 4'd5;

  // offset bits [3:2] inside the scalar group
  localparam logic [1:0] SC_VEC  = 2'd0;
  localparam logic [1:0] SC_BASE = 2'd1;
  localparam logic [1:0] SC_PROT = 2'd2;
  localparam logic [1:0] SC_NMI  = 2'd3;

  typedef struct packed {
    logic [DATA_W-1:0] pend;
    logic [DATA_W-1:0] fpend;
    logic [DATA_W-1:0] sel;
    logic [DATA_W-1:0] ena;
    logic [DATA_W-1:0] mask;
  } bank_regs_t;
endpackage

// File: rtl/pic_addr_decode.sv
module pic_addr_decode
  import banked_pic_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [3:0]        grp,
  output logic [1:0]        idx
);
  logic aligned;
  logic in_low;
  logic banked;

  always_comb begin
    grp     = addr[7:4];
    idx     = addr[3:2];
    aligned = (addr[1:0] == 2'b00);
    in_low  = (addr[ADDR_W-1:8] == '0);
    banked  = (grp >= GRP_PEND) && (grp <= GRP_MASK);
    hit     = aligned && in_low &&
              ((grp == GRP_SCALAR) || (banked && (int'(idx) < NUM_BANKS)));
  end
endmodule

// File: rtl/pic_global_regs.sv
module pic_global_regs
  import banked_pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] vec_q,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] prot_q,
  output logic [DATA_W-1:0] nmi_q
);
  logic              vec_en, base_en, prot_en, nmi_en;
  logic [DATA_W-1:0] aligned_wdata;

  always_comb begin
    vec_en        = we && (idx == SC_VEC);
    base_en       = we && (idx == SC_BASE);
    prot_en       = we && (idx == SC_PROT);
    nmi_en        = we && (idx == SC_NMI);
    aligned_wdata = {wdata[DATA_W-1:2], 2'b00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      base_q <= '0;
      prot_q <= '0;
      nmi_q  <= '0;
    end else begin
      if (vec_en)  vec_q  <= aligned_wdata;
      if (base_en) base_q <= aligned_wdata;
      if (prot_en) prot_q <= wdata;
      if (nmi_en)  nmi_q  <= wdata;
    end
  end
endmodule

// File: rtl/pic_bank.sv
module pic_bank
  import banked_pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src,
  input  logic              we,
  input  logic [3:0]        grp,
  input  logic [DATA_W-1:0] wdata,
  output bank_regs_t        regs,
  output logic              irq_any,
  output logic              fiq_any
);
  logic [DATA_W-1:0] pend_q, pend_d;
  logic [DATA_W-1:0] fpend_q, fpend_d;
  logic [DATA_W-1:0] sel_q, ena_q, mask_q;
  logic              pend_clr, fpend_clr, sel_en, ena_en, mask_en;
  logic [DATA_W-1:0] live;

  always_comb begin
    pend_clr  = we && (grp == GRP_PEND);
    fpend_clr = we && (grp == GRP_FPEND);
    sel_en    = we && (grp == GRP_SEL);
    ena_en    = we && (grp == GRP_ENA);
    mask_en   = we && (grp == GRP_MASK);
    // a level still present re-sets its bit even while it is cleared
    pend_d    = (pend_clr ? (pend_q & ~wdata) : pend_q) | src;
    fpend_d   = fpend_clr ? (fpend_q & ~wdata) : fpend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      fpend_q <= '0;
      sel_q   <= '0;
      ena_q   <= '0;
      mask_q  <= '0;
    end else begin
      pend_q  <= pend_d;
      fpend_q <= fpend_d;
      if (sel_en)  sel_q  <= wdata;
      if (ena_en)  ena_q  <= wdata;
      if (mask_en) mask_q <= wdata;
    end
  end

  always_comb begin
    live       = pend_q & ~mask_q;
    irq_any    = |live;
    fiq_any    = |(live & sel_q);
    regs.pend  = pend_q;
    regs.fpend = fpend_q;
    regs.sel   = sel_q;
    regs.ena   = ena_q;
    regs.mask  = mask_q;
  end

  // R3: without a clearing write, no pending bit drops
  p_pend_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_clr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R2: every source seen high is latched on that edge
  p_src_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|src) |=> ((pend_q & $past(src)) == $past(src)));
endmodule

// File: rtl/pic_out_stage.sv
module pic_out_stage #(
  parameter int NUM_BANKS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] irq_vec,
  input  logic [NUM_BANKS-1:0] fiq_vec,
  output logic                 irq_q,
  output logic                 fiq_q
);
  logic irq_d, fiq_d;

  always_comb begin
    irq_d = |irq_vec;
    fiq_d = |fiq_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end

  // R5: a rise of the request needs a bank asserting in the prior cycle
  p_irq_rise_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(|irq_vec));

  // R6: same for the fast request
  p_fiq_rise_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_q) |-> $past(|fiq_vec));
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import banked_pic_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  localparam int NUM_SRC  = NUM_BANKS * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  logic                 hit;
  logic [3:0]           grp;
  logic [1:0]           idx;
  logic                 scalar_we;
  logic [DATA_W-1:0]    vec_q, base_q, prot_q, nmi_q;
  bank_regs_t           bank_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] irq_vec, fiq_vec;

  pic_addr_decode #(.NUM_BANKS(NUM_BANKS)) i_dec (
    .addr(bus_addr), .hit(hit), .grp(grp), .idx(idx)
  );

  always_comb scalar_we = bus_wr && hit && (grp == GRP_SCALAR);

  pic_global_regs i_glob (
    .clk(clk), .rst_n(rst_n), .we(scalar_we), .idx(idx), .wdata(bus_wdata),
    .vec_q(vec_q), .base_q(base_q), .prot_q(prot_q), .nmi_q(nmi_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_we;
    always_comb bank_we = bus_wr && hit && (grp != GRP_SCALAR) && (int'(idx) == b);

    pic_bank i_bank (
      .clk(clk), .rst_n(rst_n),
      .src(irq_src[b*DATA_W +: DATA_W]),
      .we(bank_we), .grp(grp), .wdata(bus_wdata),
      .regs(bank_q[b]), .irq_any(irq_vec[b]), .fiq_any(fiq_vec[b])
    );
  end

  pic_out_stage #(.NUM_BANKS(NUM_BANKS)) i_out (
    .clk(clk), .rst_n(rst_n), .irq_vec(irq_vec), .fiq_vec(fiq_vec),
    .irq_q(irq_o), .fiq_q(fiq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      unique case (grp)
        GRP_SCALAR: begin
          unique case (idx)
            SC_VEC:  bus_rdata = vec_q;
            SC_BASE: bus_rdata = base_q;
            SC_PROT: bus_rdata = prot_q;
            default: bus_rdata = nmi_q;
          endcase
        end
        GRP_PEND:  bus_rdata = bank_q[idx].pend;
        GRP_FPEND: bus_rdata = bank_q[idx].fpend;
        GRP_SEL:   bus_rdata = bank_q[idx].sel;
        GRP_ENA:   bus_rdata = bank_q[idx].ena;
        default:   bus_rdata = bank_q[idx].mask;
      endcase
    end
  end

  // R6: the fast request implies the normal one
  p_fiq_needs_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> irq_o);

  // R10: misaligned or high offsets read zero
  p_unmapped_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr[1:0] != 2'b00) || (bus_addr[ADDR_W-1:7] != '0)) |-> (bus_rdata == '0));

  // R8: vector and base never show low address bits
  p_vec_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == 10'h000) || (bus_addr == 10'h004)) |-> (bus_rdata[1:0] == 2'b00));
endmodule

// File: tb/test_banked_irq_ctrl.sv
`timescale 1ns/1ps
module test_banked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] irq_src = '0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  banked_irq_ctrl i_banked_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [95:0] v);
    @(negedge clk);
    irq_src = v;
    @(negedge clk);
    irq_src = '0;
  endtask

  function automatic logic [31:0] selpat(input int b);
    return 32'hA5C3_0F69 ^ (32'h1111_1111 * b);
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int g = 0; g < 6; g++)
      for (int b = 0; b < 4; b++) begin
        if (g > 0 && b == 3) continue;
        rd(10'(g * 16 + b * 4), d);
        check("R1 reset register", d, 32'h0);
      end
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    check("R1 fiq after reset", {31'b0, fiq_o}, 32'h0);

    // R8: scalar storage
    wr(10'h000, 32'hFFFF_FFFF); rd(10'h000, d); check("R8 vector low bits", d, 32'hFFFF_FFFC);
    wr(10'h004, 32'h1234_5677); rd(10'h004, d); check("R8 base low bits", d, 32'h1234_5674);
    rd(10'h000, d); check("R8 vector untouched by base", d, 32'hFFFF_FFFC);
    wr(10'h008, 32'hDEAD_BEEF); rd(10'h008, d); check("R8 protect full", d, 32'hDEAD_BEEF);
    wr(10'h00C, 32'h0000_0003); rd(10'h00C, d); check("R8 nmi full", d, 32'h0000_0003);

    // R11: select per bank, no cross-bank spill
    for (int b = 0; b < 3; b++) wr(10'(10'h030 + b * 4), selpat(b));
    for (int b = 0; b < 3; b++) begin
      rd(10'(10'h030 + b * 4), d); check("R11 select bank readback", d, selpat(b));
    end

    // R2/R3/R4/R5/R6: sweep every source
    for (int n = 0; n < 96; n++) begin
      int bk = n / 32;
      int bt = n % 32;
      logic [95:0] v = 96'b1 << n;
      @(negedge clk);
      irq_src = v;
      @(negedge clk);
      irq_src = '0;
      if (n == 0) check("R5 irq one clock after capture", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      check("R5 irq for source", {31'b0, irq_o}, 32'h1);
      check("R6 fiq for source", {31'b0, fiq_o}, {31'b0, selpat(bk)[bt]});
      for (int b = 0; b < 3; b++) begin
        rd(10'(10'h010 + b * 4), d);
        check("R2 R3 pending position", d, (b == bk) ? (32'h1 << bt) : 32'h0);
      end
      wr(10'(10'h010 + bk * 4), 32'h1 << bt);
      rd(10'(10'h010 + bk * 4), d); check("R4 cleared", d, 32'h0);
      @(negedge clk);
      check("R5 irq drops after clear", {31'b0, irq_o}, 32'h0);
    end

    // R9: fast-pending never set
    pulse({96{1'b1}});
    for (int b = 0; b < 3; b++) begin
      rd(10'(10'h020 + b * 4), d); check("R9 fast pending zero", d, 32'h0);
    end
    for (int b = 0; b < 3; b++) wr(10'(10'h010 + b * 4), 32'hFFFF_FFFF);

    // R4: partial clear, and clear while source held
    pulse(96'h3 << 40);
    wr(10'h014, 32'h0000_0100);
    rd(10'h014, d); check("R4 partial clear", d, 32'h0000_0200);
    @(negedge clk); irq_src = 96'h1 << 70;
    wr(10'h018, 32'h0000_0040);
    rd(10'h018, d); check("R4 held source re-sets", d, 32'h0000_0040);
    irq_src = '0;
    wr(10'h018, 32'h0000_0040);
    rd(10'h018, d); check("R3 cleared after source fell", d, 32'h0);
    wr(10'h014, 32'hFFFF_FFFF);

    // R5/R6 mask gating; R7 enable no effect
    pulse(96'h1 << 33);           // bank 1 bit 1, selpat(1) bit1
    wr(10'h054, 32'h0000_0002);
    @(negedge clk);
    check("R5 masked irq low", {31'b0, irq_o}, 32'h0);
    check("R6 masked fiq low", {31'b0, fiq_o}, 32'h0);
    rd(10'h014, d); check("R3 masked still pending", d, 32'h2);
    wr(10'h044, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R7 enable does not ungate", {31'b0, irq_o}, 32'h0);
    wr(10'h054, 32'h0);
    @(negedge clk);
    check("R5 unmask irq high", {31'b0, irq_o}, 32'h1);
    check("R6 unmask fiq", {31'b0, fiq_o}, {31'b0, selpat(1)[1]});
    wr(10'h044, 32'h0);
    @(negedge clk);
    check("R7 enable zero keeps irq", {31'b0, irq_o}, 32'h1);
    wr(10'h048, 32'h5A5A_0001);
    rd(10'h048, d); check("R7 enable readback", d, 32'h5A5A_0001);
    wr(10'h034, 32'h0);
    @(negedge clk);
    check("R6 deselect fiq low", {31'b0, fiq_o}, 32'h0);
    check("R5 irq stays without select", {31'b0, irq_o}, 32'h1);
    wr(10'h014, 32'h2);

    // R10: unmapped offsets
    wr(10'h050, 32'h0000_00F0);
    wr(10'h05C, 32'hFFFF_FFFF);
    wr(10'h052, 32'hFFFF_FFFF);
    wr(10'h060, 32'hFFFF_FFFF);
    wr(10'h3FC, 32'hFFFF_FFFF);
    wr(10'h1C0, 32'hFFFF_FFFF);
    rd(10'h050, d); check("R10 mask untouched", d, 32'h0000_00F0);
    rd(10'h000, d); check("R10 vector untouched", d, 32'hFFFF_FFFC);
    rd(10'h05C, d); check("R10 bank3 reads zero", d, 32'h0);
    rd(10'h052, d); check("R10 misaligned reads zero", d, 32'h0);
    rd(10'h060, d); check("R10 high group reads zero", d, 32'h0);
    rd(10'h3FC, d); check("R10 top reads zero", d, 32'h0);
    rd(10'h01C, d); check("R10 pending bank3 zero", d, 32'h0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule